// File: doc/BRIEF.md
# Fractional flash clock divider

This block produces a slower clock for a serial flash interface from a fast source clock, and it runs entirely in that source clock domain. The division ratio is a whole number from 2 to 5. A half step can be added to it, and in that case a duty-bias bit chooses whether the high phase is the longer or the shorter part of each period. Two divided outputs are provided. The plain output has no offset. The shifted output starts a programmable number of source cycles later, which lets the sampling point of the flash data be tuned.

Each output has its own enable and its own ready flag. A divider starts only when it sees its enable go from low to high. At that edge it captures the ratio, half-step, duty and phase settings. Changes to those settings while the divider runs have no effect until the next start. Dropping an enable stops that output at once.

Top module: `flash_clk_frac_div`

## Requirements
- R1: With `halfStep` = 0, every output period lasts `ratioCode` + 2 source cycles (code 0 gives 2, code 1 gives 3, code 2 gives 4, code 3 gives 5). The high phase is ceil(P/2) cycles, and the value of `dutyHigh` makes no difference.
- R2: With `halfStep` = 1, the periods alternate N, N+1, N, N+1, and so on, where N = `ratioCode` + 2. The first period after a start is N cycles long.
- R3: With `halfStep` = 1, each period of length P is high for ceil(P/2) cycles when `dutyHigh` = 1 and for floor(P/2) cycles when `dutyHigh` = 0. The high phase always comes first in the period.
- R4: A divider starts only on a low-to-high transition of its enable that is sampled at a source clock edge. In the cycle after that start edge the output is low. The plain output goes high at the next edge. Holding the enable high never restarts the divider.
- R5: When both enables rise at the same edge, the shifted output follows the plain waveform delayed by D = min(`phaseCount`, N-1) source cycles.
- R6: Changes to `ratioCode`, `halfStep`, `dutyHigh` or `phaseCount` while a divider runs leave its waveform unchanged.
- R7: One source edge after an enable is sampled low, that output is low and its ready flag is clear.
- R8: A ready flag rises together with the second rising edge of its output, that is, after the first complete period, and it stays high while the divider runs.
- R9: During reset and after it, until an enable rises, both outputs and both ready flags are low.
- R10: The two channels are independent. Disabling one leaves the other output toggling with its ready flag still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratioCode | input | 2 | Whole ratio code; the ratio is code + 2 |
| halfStep | input | 1 | Adds one half to the ratio |
| dutyHigh | input | 1 | Duty bias in half-step mode: 1 makes the high phase longer |
| phaseCount | input | 3 | Lag of the shifted output, in source cycles |
| plainEn | input | 1 | Enable of the plain output; it starts on a rising edge |
| shiftEn | input | 1 | Enable of the shifted output; it starts on a rising edge |
| plainClk | output | 1 | Divided clock with no offset |
| plainReady | output | 1 | Plain divider running and past its first period |
| shiftClk | output | 1 | Divided clock with the phase offset |
| shiftReady | output | 1 | Shifted divider running and past its first period |

## Verification
The bench compares each output sample against its own waveform model for all sixteen combinations of ratio code, half step and duty bit. Each combination uses a phase count that is below, equal to or above the clamp. A design that alternated the period lengths in the wrong order, applied the duty bit in whole-ratio mode, or clamped the phase to the wrong limit would fail at the first differing sample. Halfway through every run the settings are scrambled, which catches a design that follows live inputs instead of the values captured at start. Directed tests drop one enable while the other keeps running, then re-raise it after a single low cycle. These catch a divider that keeps running while disabled, that lets the ready flag stay set after a stop, or that starts from the enable level instead of its edge.

// File: rtl/flash_div_pkg.sv
`timescale 1ns/1ps
package flash_div_pkg;
  // Widths of the setting inputs
  localparam int RATIO_W    = 2;
  localparam int PHASE_W    = 3;
  localparam int RATIO_BASE = 2;
  // Longest period: largest whole ratio plus the half-step cycle
  localparam int MAX_LEN    = RATIO_BASE + (1 << RATIO_W);
  localparam int CNT_W      = $clog2(MAX_LEN + 1);

  // Settings captured at a start edge
  typedef struct packed {
    logic [CNT_W-1:0]   baseLen;
    logic               half;
    logic               dutyLong;
    logic [PHASE_W-1:0] delay;
  } div_cfg_t;

  // Strobes from the control to one datapath channel
  typedef struct packed {
    logic start;
    logic halt;
  } div_strobe_t;
endpackage

// File: rtl/flash_div_ctrl.sv
`timescale 1ns/1ps
module flash_div_ctrl
  import flash_div_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [RATIO_W-1:0]          ratioCode,
  input  logic                        halfStep,
  input  logic                        dutyHigh,
  input  logic [PHASE_W-1:0]          phaseCount,
  input  logic [NUM_CH-1:0]           en,
  output div_strobe_t [NUM_CH-1:0]    strobe,
  output div_cfg_t    [NUM_CH-1:0]    cfg
);
  localparam int WIDE = PHASE_W + CNT_W;

  logic [NUM_CH-1:0]  enPrev;
  logic [CNT_W-1:0]   baseLen;
  logic [PHASE_W-1:0] clampedDelay;
  logic               effDuty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enPrev <= '0;
    else        enPrev <= en;
  end

  // The ratio code is offset by the base, and the phase is clamped to one below the first period
  always_comb begin
    logic [WIDE-1:0] maxDelay;
    logic [WIDE-1:0] reqDelay;
    baseLen  = CNT_W'(ratioCode) + CNT_W'(RATIO_BASE);
    maxDelay = WIDE'(baseLen) - WIDE'(1);
    reqDelay = WIDE'(phaseCount);
    clampedDelay = (reqDelay > maxDelay) ? PHASE_W'(maxDelay) : phaseCount;
    effDuty = halfStep ? dutyHigh : 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign strobe[ch].start = en[ch] & ~enPrev[ch];
    assign strobe[ch].halt  = ~en[ch];
    assign cfg[ch].baseLen  = baseLen;
    assign cfg[ch].half     = halfStep;
    assign cfg[ch].dutyLong = effDuty;
    if (ch == 0) begin : g_plain
      assign cfg[ch].delay = '0;
    end else begin : g_shift
      assign cfg[ch].delay = clampedDelay;
    end
  end
endmodule

// File: rtl/flash_div_path.sv
`timescale 1ns/1ps
module flash_div_path
  import flash_div_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  div_strobe_t strobe,
  input  div_cfg_t    cfgIn,
  output logic        clkOut,
  output logic        ready
);
  div_cfg_t           cfgHeld;
  logic               running;
  logic [PHASE_W-1:0] delayLeft;
  logic [CNT_W-1:0]   pos;
  logic               oddPeriod;
  logic               wrapped;
  logic               outReg;
  logic               readyReg;

  logic [CNT_W-1:0]   curLen;
  logic [CNT_W-1:0]   highLen;
  logic               lastPos;

  // Length of the current period and its high phase
  always_comb begin
    curLen  = cfgHeld.baseLen + CNT_W'(cfgHeld.half & oddPeriod);
    highLen = cfgHeld.dutyLong ? CNT_W'((curLen + CNT_W'(1)) >> 1)
                               : CNT_W'(curLen >> 1);
    lastPos = (pos == curLen - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgHeld   <= '0;
      running   <= 1'b0;
      delayLeft <= '0;
      pos       <= '0;
      oddPeriod <= 1'b0;
      wrapped   <= 1'b0;
      outReg    <= 1'b0;
      readyReg  <= 1'b0;
    end else if (strobe.halt) begin
      running  <= 1'b0;
      outReg   <= 1'b0;
      readyReg <= 1'b0;
    end else if (strobe.start) begin
      cfgHeld   <= cfgIn;
      running   <= 1'b1;
      delayLeft <= cfgIn.delay;
      pos       <= '0;
      oddPeriod <= 1'b0;
      wrapped   <= 1'b0;
      outReg    <= 1'b0;
      readyReg  <= 1'b0;
    end else if (running) begin
      if (delayLeft != '0) begin
        delayLeft <= delayLeft - PHASE_W'(1);
      end else begin
        outReg <= (pos < highLen);
        if (lastPos) begin
          pos       <= '0;
          oddPeriod <= ~oddPeriod;
          wrapped   <= 1'b1;
        end else begin
          pos <= pos + CNT_W'(1);
        end
        if (pos == '0 && wrapped) readyReg <= 1'b1;
      end
    end
  end

  assign clkOut = outReg;
  assign ready  = readyReg;
endmodule

// File: rtl/flash_clk_frac_div.sv
`timescale 1ns/1ps
module flash_clk_frac_div
  import flash_div_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratioCode,
  input  logic               halfStep,
  input  logic               dutyHigh,
  input  logic [PHASE_W-1:0] phaseCount,
  input  logic               plainEn,
  input  logic               shiftEn,
  output logic               plainClk,
  output logic               plainReady,
  output logic               shiftClk,
  output logic               shiftReady
);
  localparam int NUM_CH = 2;

  div_strobe_t [NUM_CH-1:0] strobe;
  div_cfg_t    [NUM_CH-1:0] cfg;
  logic        [NUM_CH-1:0] chClk;
  logic        [NUM_CH-1:0] chReady;

  flash_div_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .ratioCode(ratioCode), .halfStep(halfStep), .dutyHigh(dutyHigh),
    .phaseCount(phaseCount), .en({shiftEn, plainEn}),
    .strobe(strobe), .cfg(cfg)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_path
    flash_div_path path_i (
      .clk(clk), .rst_n(rst_n),
      .strobe(strobe[ch]), .cfgIn(cfg[ch]),
      .clkOut(chClk[ch]), .ready(chReady[ch])
    );
  end

  assign plainClk   = chClk[0];
  assign plainReady = chReady[0];
  assign shiftClk   = chClk[1];
  assign shiftReady = chReady[1];
endmodule

// File: rtl/flash_clk_frac_div_chk.sv
`timescale 1ns/1ps
module flash_clk_frac_div_chk (
  input logic clk,
  input logic rst_n,
  input logic plainEn,
  input logic shiftEn,
  input logic plainClk,
  input logic plainReady,
  input logic shiftClk,
  input logic shiftReady
);
  assert_halt_plain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !plainEn |=> (!plainClk && !plainReady));
  assert_halt_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shiftEn |=> (!shiftClk && !shiftReady));
  assert_ready_edge_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(plainReady) |-> plainClk);
  assert_ready_edge_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shiftReady) |-> shiftClk);
  assert_start_low_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(plainEn) |=> (!plainClk && !plainReady));
  assert_start_low_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shiftEn) |=> (!shiftClk && !shiftReady));
endmodule

bind flash_clk_frac_div flash_clk_frac_div_chk chk_i (.*);

// File: tb/flash_clk_frac_div_tb_top.sv
`timescale 1ns/1ps
module flash_clk_frac_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ratioCode = '0;
  logic       halfStep = 1'b0;
  logic       dutyHigh = 1'b0;
  logic [2:0] phaseCount = '0;
  logic       plainEn = 1'b0;
  logic       shiftEn = 1'b0;
  logic       plainClk, plainReady, shiftClk, shiftReady;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_clk_frac_div dut_i (.*);

  typedef struct packed {
    logic [1:0] code;
    logic       half;
    logic       duty;
    logic [2:0] phase;
    logic [2:0] expDelay;
  } vec_t;

  // Stimulus with the expected clamped lag min(phase, code+1)
  localparam vec_t VECS [16] = '{
    '{2'd0, 1'b0, 1'b0, 3'd7, 3'd1}, '{2'd0, 1'b0, 1'b1, 3'd0, 3'd0},
    '{2'd0, 1'b1, 1'b0, 3'd1, 3'd1}, '{2'd0, 1'b1, 1'b1, 3'd5, 3'd1},
    '{2'd1, 1'b0, 1'b0, 3'd2, 3'd2}, '{2'd1, 1'b0, 1'b1, 3'd7, 3'd2},
    '{2'd1, 1'b1, 1'b0, 3'd1, 3'd1}, '{2'd1, 1'b1, 1'b1, 3'd3, 3'd2},
    '{2'd2, 1'b0, 1'b0, 3'd3, 3'd3}, '{2'd2, 1'b0, 1'b1, 3'd6, 3'd3},
    '{2'd2, 1'b1, 1'b0, 3'd2, 3'd2}, '{2'd2, 1'b1, 1'b1, 3'd0, 3'd0},
    '{2'd3, 1'b0, 1'b0, 3'd4, 3'd4}, '{2'd3, 1'b0, 1'b1, 3'd7, 3'd4},
    '{2'd3, 1'b1, 1'b0, 3'd3, 3'd3}, '{2'd3, 1'b1, 1'b1, 3'd5, 3'd4}
  };

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // Model of sample i after the start edge (sample 0 follows the start edge)
  function automatic bit expBit(int i, int n, bit half, bit duty, int d);
    int p;
    int len;
    bit effD;
    if (i < 1 + d) return 1'b0;
    p = i - 1 - d;
    effD = half ? duty : 1'b1;
    for (int k = 0; k < 64; k++) begin
      len = n + ((half && (k % 2 == 1)) ? 1 : 0);
      if (p < len) return (p < (effD ? (len + 1) / 2 : len / 2));
      p -= len;
    end
    return 1'b0;
  endfunction

  // Plain channel only: compare len samples after a start driven just before
  task automatic runPlain(int n, bit half, bit duty, int len, string req, string what);
    int bad = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (plainClk !== expBit(i, n, half, duty, 0)) bad++;
      if (plainReady !== (i >= 1 + n)) bad++;
    end
    check(bad == 0, req, what, bad, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!plainClk && !plainReady && !shiftClk && !shiftReady, "R9", "outputs in reset",
          {plainClk, plainReady, shiftClk, shiftReady}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!plainClk && !plainReady && !shiftClk && !shiftReady, "R9", "outputs idle after reset",
          {plainClk, plainReady, shiftClk, shiftReady}, 0);

    // Table walk: every code, half-step and duty setting
    foreach (VECS[v]) begin
      int n;
      int d;
      int badPlain;
      int badShift;
      int badReady;
      int badLate;
      string wreq;
      n = int'(VECS[v].code) + 2;
      d = int'(VECS[v].expDelay);
      badPlain = 0; badShift = 0; badReady = 0; badLate = 0;
      plainEn = 1'b0; shiftEn = 1'b0;
      repeat (2) @(negedge clk);
      ratioCode = VECS[v].code; halfStep = VECS[v].half;
      dutyHigh = VECS[v].duty; phaseCount = VECS[v].phase;
      plainEn = 1'b1; shiftEn = 1'b1;
      for (int i = 0; i < 40; i++) begin
        bit ep, es;
        @(negedge clk);
        ep = expBit(i, n, VECS[v].half, VECS[v].duty, 0);
        es = expBit(i, n, VECS[v].half, VECS[v].duty, d);
        if (i < 20) begin
          if (plainClk !== ep) badPlain++;
          if (shiftClk !== es) badShift++;
          if (plainReady !== (i >= 1 + n) || shiftReady !== (i >= 1 + d + n)) badReady++;
        end else begin
          if (plainClk !== ep || shiftClk !== es || plainReady !== 1'b1 || shiftReady !== 1'b1)
            badLate++;
        end
        if (i == 19) begin
          ratioCode = ~VECS[v].code; halfStep = ~VECS[v].half;
          dutyHigh = ~VECS[v].duty; phaseCount = ~VECS[v].phase;
        end
      end
      wreq = VECS[v].half ? "R2 R3" : "R1 R3";
      check(badPlain == 0, wreq, $sformatf("plain waveform vec %0d", v), badPlain, 0);
      check(badShift == 0, "R5", $sformatf("shifted waveform vec %0d", v), badShift, 0);
      check(badReady == 0, "R8", $sformatf("ready timing vec %0d", v), badReady, 0);
      check(badLate == 0, "R6", $sformatf("settings change ignored vec %0d", v), badLate, 0);
    end

    // R7 and R10: drop only the plain enable while both run
    @(negedge clk);
    plainEn = 1'b0;
    @(negedge clk);
    check(!plainClk && !plainReady, "R7", "plain stopped one edge after disable",
          {plainClk, plainReady}, 0);
    check(shiftReady == 1'b1, "R10", "shift ready kept", shiftReady, 1);
    begin
      int toggles = 0;
      int plainHigh = 0;
      bit prev = shiftClk;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (shiftClk != prev) toggles++;
        prev = shiftClk;
        if (plainClk || plainReady) plainHigh++;
      end
      check(toggles > 0, "R10", "shift keeps toggling", toggles, 1);
      check(plainHigh == 0, "R7", "plain held low while disabled", plainHigh, 0);
    end
    shiftEn = 1'b0;
    @(negedge clk);
    check(!shiftClk && !shiftReady, "R7", "shift stopped one edge after disable",
          {shiftClk, shiftReady}, 0);

    // R4: level held high runs without restart
    ratioCode = 2'd0; halfStep = 1'b0; dutyHigh = 1'b0;
    plainEn = 1'b1;
    runPlain(2, 1'b0, 1'b0, 30, "R4", "start on edge then held level");

    // R4: one low cycle, then a new rising edge restarts with new settings
    plainEn = 1'b0;
    @(negedge clk);
    ratioCode = 2'd3; halfStep = 1'b1; dutyHigh = 1'b0;
    plainEn = 1'b1;
    runPlain(5, 1'b1, 1'b0, 30, "R4", "restart on new rising edge");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule